// File: doc/BRIEF.md
# Request Parser and Acknowledge Responder

This block is the clock-slave half of a 32-bit word link. While it holds the slave role, each received word arrives with a one-cycle strobe. The block checks the first word for the sync tag. It stores every word of the request in an external receive buffer and answers payload words with the poll pattern. Once the request is complete, it decides whether to accept or reject the command and builds the acknowledge frame in hardware. It hands that frame out one word at a time, each time the peer returns the poll pattern.

When an accepted frame finishes, the block clears its transmit word, takes the master role and reports the request length and command to the host. When a rejected frame finishes, it reports the rejection code, clears its indices and waits for a fresh request as a slave. A watchdog returns the block to the header wait if the peer goes quiet in the middle of a frame. A pulse on the slave-entry input hands the block back from the master role.

Top module: `req_ack_slave`

## Requirements
- R1: A first word whose bits 31:16 differ from 0x9966 is still written to buffer index 0. The block keeps waiting for a header, leaves txWord unchanged and makes no report.
- R2: A valid header with a non-zero length in bits 15:8 makes txWord 0x8000_0000 on the next cycle. Each following word is written at buffer indices 1, 2, … and is answered with 0x8000_0000 until the index exceeds the length.
- R3: A zero-length header whose command in bits 7:0 is in the zero-length allowed set (default 0x27, 0x28, 0x29, 0x36) makes txWord 0x9966_0000 | (command + 0x80) on the next cycle.
- R4: A zero-length header whose command is outside that set makes txWord 0x9966_01EE on the next cycle.
- R5: In a rejection, the first poll (0x8000_0000) after the header makes txWord the reason word. The reason is 1 when the command lies in 0x10..0x3D inclusive, and 2 otherwise.
- R6: At the end of a request that carries a payload, the command is accepted only if it is in the payload allowed set (default 0x28, 0x29, 0x36). Otherwise it is rejected as in R4.
- R7: During the acknowledge phase, a received word other than 0x8000_0000 leaves txWord unchanged and does not advance the frame.
- R8: A poll after the last word of an accepted acknowledge pulses doneValid for one cycle with doneCode = (length << 8) | command. In that same cycle isMaster becomes 1 and txWord becomes 0.
- R9: A poll after the reason word pulses doneValid with doneCode 0x01EE. The block stays a slave, and the next header is parsed from a cleared state.
- R10: While isMaster is 1, received words cause no buffer write and no change to txWord. A pulse on enterSlave returns the block to the header wait.
- R11: Once a word has been received in a frame, WD_CYCLES consecutive cycles without a word pulse wdExpire for one cycle and return the block to the header wait. Any received word restarts the count.
- R12: After reset the block is a slave waiting for a header, with txWord 0 and no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe: a word was received |
| rxWord | input | 32 | Received word |
| enterSlave | input | 1 | Return from the master role to the header wait |
| txWord | output | 32 | Word presented for the next transfer |
| bufWe | output | 1 | Receive buffer write enable |
| bufAddr | output | 8 | Receive buffer index |
| bufData | output | 32 | Receive buffer write data |
| isMaster | output | 1 | Block has handed back to the master role |
| doneValid | output | 1 | One-cycle completion report strobe |
| doneCode | output | 16 | Completion code |
| wdExpire | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The bench overrides WD_CYCLES to 20 and keeps the default command sets and reason range. The short watchdog period makes the restart-on-word behaviour and the exact expiry cycle reachable in a few dozen cycles. The default sets cover both sides of the distinction: 0x27 is accepted only with zero length, so the same command is accepted or rejected depending on its length. Reason words 1 and 2 are both reached with commands inside and outside 0x10..0x3D.

// File: rtl/req_ack_pkg.sv
`timescale 1ns/1ps
package req_ack_pkg;
  localparam int unsigned LEN_W = 8;
  localparam int unsigned DONE_W = LEN_W + 8;
  localparam logic [15:0] SYNC_TAG = 16'h9966;
  localparam logic [31:0] POLL_WORD = 32'h8000_0000;
  localparam logic [31:0] REJ_HDR = 32'h9966_01EE;
  localparam logic [15:0] REJ_CODE = 16'h01EE;

  typedef enum logic [1:0] {S_HDR, S_PAY, S_ACK, S_MST} state_e;

  typedef struct packed {
    logic loadHdr;
    logic sendPoll;
    logic sendAckHdr;
    logic rejectCmd;
    logic sendReason;
    logic clearTx;
    logic reportOk;
    logic reportRej;
  } strobe_t;
endpackage

// File: rtl/req_ack_dpath.sv
`timescale 1ns/1ps
module req_ack_dpath
  import req_ack_pkg::*;
#(
  parameter int unsigned N_ZERO = 4,
  parameter logic [N_ZERO*8-1:0] ZERO_CMDS = {8'h27, 8'h28, 8'h29, 8'h36},
  parameter int unsigned N_PAY = 3,
  parameter logic [N_PAY*8-1:0] PAY_CMDS = {8'h28, 8'h29, 8'h36},
  parameter logic [7:0] REJ_LO = 8'h10,
  parameter logic [7:0] REJ_HI = 8'h3D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       rxWord,
  input  strobe_t           st,
  output logic [LEN_W-1:0]  reqLen,
  output logic              hdrValid,
  output logic              zeroOk,
  output logic              payOk,
  output logic [31:0]       txWord,
  output logic              doneValid,
  output logic [DONE_W-1:0] doneCode
);
  logic [7:0] reqCmd;
  logic [7:0] curCmd;
  logic [31:0] reasonWord;
  logic [31:0] ackHdr;
  logic inRange;
  logic [N_ZERO-1:0] zeroHit;
  logic [N_PAY-1:0] payHit;

  // each allowed-set entry gets its own comparator
  for (genvar i = 0; i < N_ZERO; i++) begin : g_zero
    assign zeroHit[i] = (rxWord[7:0] == ZERO_CMDS[i*8 +: 8]);
  end
  for (genvar j = 0; j < N_PAY; j++) begin : g_pay
    assign payHit[j] = (reqCmd == PAY_CMDS[j*8 +: 8]);
  end

  assign zeroOk   = |zeroHit;
  assign payOk    = |payHit;
  assign hdrValid = (rxWord[31:16] == SYNC_TAG);
  assign curCmd   = st.loadHdr ? rxWord[7:0] : reqCmd;
  assign inRange  = (curCmd >= REJ_LO) && (curCmd <= REJ_HI);
  assign ackHdr   = {SYNC_TAG, 16'h0000} | {16'h0000, {8'h00, curCmd} + 16'h0080};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqLen     <= '0;
      reqCmd     <= '0;
      txWord     <= '0;
      reasonWord <= '0;
      doneValid  <= 1'b0;
      doneCode   <= '0;
    end else begin
      doneValid <= st.reportOk | st.reportRej;
      if (st.loadHdr) begin
        reqLen <= rxWord[15:8];
        reqCmd <= rxWord[7:0];
      end
      if (st.sendPoll) txWord <= POLL_WORD;
      if (st.sendAckHdr) begin
        txWord     <= st.rejectCmd ? REJ_HDR : ackHdr;
        reasonWord <= inRange ? 32'd1 : 32'd2;
      end
      if (st.sendReason) txWord <= reasonWord;
      if (st.clearTx) txWord <= '0;
      if (st.reportOk) doneCode <= {reqLen, reqCmd};
      if (st.reportRej) doneCode <= DONE_W'(REJ_CODE);
    end
  end
endmodule

// File: rtl/req_ack_ctrl.sv
`timescale 1ns/1ps
module req_ack_ctrl
  import req_ack_pkg::*;
#(
  parameter int unsigned WD_CYCLES = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [31:0]      rxWord,
  input  logic             enterSlave,
  input  logic             hdrValid,
  input  logic             zeroOk,
  input  logic             payOk,
  input  logic [LEN_W-1:0] reqLen,
  output strobe_t          st,
  output logic             isMaster,
  output logic             wdExpire,
  output logic             bufWe,
  output logic [LEN_W-1:0] bufAddr
);
  localparam int unsigned WD_W = $clog2(WD_CYCLES + 1);

  state_e state;
  logic [LEN_W:0] reqNext;
  logic [1:0] ackNext;
  logic rejFlag;
  logic armed;
  logic [WD_W-1:0] wdCnt;
  logic isPoll, slaveRx, lastPay, ackDone;

  assign isMaster = (state == S_MST);
  assign isPoll   = (rxWord == POLL_WORD);
  assign slaveRx  = rxValid && !isMaster;
  assign lastPay  = ({1'b0, reqLen} < reqNext + 1'b1);
  assign ackDone  = rejFlag ? (ackNext > 2'd1) : (ackNext > 2'd0);

  always_comb begin
    st = '0;
    bufWe = 1'b0;
    bufAddr = '0;
    if (slaveRx) begin
      case (state)
        S_HDR: begin
          bufWe = 1'b1;
          if (hdrValid) begin
            st.loadHdr = 1'b1;
            if (rxWord[15:8] == '0) begin
              st.sendAckHdr = 1'b1;
              st.rejectCmd  = !zeroOk;
            end else begin
              st.sendPoll = 1'b1;
            end
          end
        end
        S_PAY: begin
          bufWe   = 1'b1;
          bufAddr = reqNext[LEN_W-1:0];
          if (lastPay) begin
            st.sendAckHdr = 1'b1;
            st.rejectCmd  = !payOk;
          end else begin
            st.sendPoll = 1'b1;
          end
        end
        S_ACK: begin
          if (isPoll) begin
            if (!ackDone) st.sendReason = 1'b1;
            else if (rejFlag) st.reportRej = 1'b1;
            else begin
              st.reportOk = 1'b1;
              st.clearTx  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_HDR;
      reqNext  <= '0;
      ackNext  <= '0;
      rejFlag  <= 1'b0;
      armed    <= 1'b0;
      wdCnt    <= '0;
      wdExpire <= 1'b0;
    end else begin
      wdExpire <= 1'b0;
      if (isMaster) begin
        if (enterSlave) state <= S_HDR;
      end else if (rxValid) begin
        armed <= 1'b1;
        wdCnt <= WD_W'(WD_CYCLES - 1);
        if (st.sendAckHdr) begin
          state   <= S_ACK;
          ackNext <= 2'd1;
          rejFlag <= st.rejectCmd;
        end else if (st.sendPoll && state == S_HDR) begin
          state   <= S_PAY;
          reqNext <= 1;
        end
        if (state == S_PAY) reqNext <= reqNext + 1'b1;
        if (st.sendReason) ackNext <= ackNext + 2'd1;
        if (st.reportOk || st.reportRej) begin
          state   <= st.reportOk ? S_MST : S_HDR;
          reqNext <= '0;
          ackNext <= '0;
          rejFlag <= 1'b0;
          armed   <= 1'b0;
        end
      end else if (armed) begin
        if (wdCnt == '0) begin
          wdExpire <= 1'b1;
          state    <= S_HDR;
          reqNext  <= '0;
          ackNext  <= '0;
          rejFlag  <= 1'b0;
          armed    <= 1'b0;
        end else begin
          wdCnt <= wdCnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/req_ack_slave.sv
`timescale 1ns/1ps
module req_ack_slave
  import req_ack_pkg::*;
#(
  parameter int unsigned WD_CYCLES = 2000,
  parameter int unsigned N_ZERO = 4,
  parameter logic [N_ZERO*8-1:0] ZERO_CMDS = {8'h27, 8'h28, 8'h29, 8'h36},
  parameter int unsigned N_PAY = 3,
  parameter logic [N_PAY*8-1:0] PAY_CMDS = {8'h28, 8'h29, 8'h36},
  parameter logic [7:0] REJ_LO = 8'h10,
  parameter logic [7:0] REJ_HI = 8'h3D
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [31:0] rxWord,
  input  logic        enterSlave,
  output logic [31:0] txWord,
  output logic        bufWe,
  output logic [7:0]  bufAddr,
  output logic [31:0] bufData,
  output logic        isMaster,
  output logic        doneValid,
  output logic [15:0] doneCode,
  output logic        wdExpire
);
  strobe_t st;
  logic [LEN_W-1:0] reqLen;
  logic hdrValid, zeroOk, payOk;

  assign bufData = rxWord;

  req_ack_ctrl #(.WD_CYCLES(WD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxWord(rxWord),
    .enterSlave(enterSlave), .hdrValid(hdrValid), .zeroOk(zeroOk),
    .payOk(payOk), .reqLen(reqLen), .st(st), .isMaster(isMaster),
    .wdExpire(wdExpire), .bufWe(bufWe), .bufAddr(bufAddr)
  );

  req_ack_dpath #(
    .N_ZERO(N_ZERO), .ZERO_CMDS(ZERO_CMDS), .N_PAY(N_PAY),
    .PAY_CMDS(PAY_CMDS), .REJ_LO(REJ_LO), .REJ_HI(REJ_HI)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .rxWord(rxWord), .st(st), .reqLen(reqLen),
    .hdrValid(hdrValid), .zeroOk(zeroOk), .payOk(payOk), .txWord(txWord),
    .doneValid(doneValid), .doneCode(doneCode)
  );
endmodule

// File: rtl/req_ack_slave_checker.sv
`timescale 1ns/1ps
module req_ack_slave_checker (
  input logic        clk,
  input logic        rstN,
  input logic        bufWe,
  input logic [7:0]  bufAddr,
  input logic [31:0] bufData,
  input logic [31:0] txWord,
  input logic        isMaster,
  input logic        doneValid,
  input logic [15:0] doneCode,
  input logic        wdExpire
);
  assert_bad_hdr_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    bufWe && bufAddr == 8'd0 && bufData[31:16] != 16'h9966 |=> $stable(txWord) && !doneValid);

  assert_poll_reply_R2: assert property (@(posedge clk) disable iff (!rstN)
    bufWe && bufAddr == 8'd0 && bufData[31:16] == 16'h9966 && bufData[15:8] != 8'd0
    |=> txWord == 32'h8000_0000);

  assert_ack_hdr_tag_R3: assert property (@(posedge clk) disable iff (!rstN)
    bufWe && bufAddr == 8'd0 && bufData[31:16] == 16'h9966 && bufData[15:8] == 8'd0
    |=> txWord[31:16] == 16'h9966);

  assert_ok_to_master_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneCode != 16'h01EE |-> isMaster && txWord == 32'd0);

  assert_rej_stays_slave_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneCode == 16'h01EE |-> !isMaster);

  assert_master_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    isMaster |-> !bufWe);

  assert_wd_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    wdExpire |-> !isMaster && !doneValid);

  assert_wd_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    wdExpire |=> !wdExpire);
endmodule

bind req_ack_slave req_ack_slave_checker u_chk (
  .clk(clk), .rstN(rstN), .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData),
  .txWord(txWord), .isMaster(isMaster), .doneValid(doneValid),
  .doneCode(doneCode), .wdExpire(wdExpire)
);

// File: tb/req_ack_slave_bench.sv
`timescale 1ns/1ps
module req_ack_slave_bench;
  localparam int W = 20;
  localparam logic [31:0] POLL = 32'h8000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0;
  logic [31:0] rxWord = '0;
  logic enterSlave = 1'b0;
  logic [31:0] txWord, bufData;
  logic bufWe, isMaster, doneValid, wdExpire;
  logic [7:0] bufAddr;
  logic [15:0] doneCode;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  req_ack_slave #(.WD_CYCLES(W)) u_req_ack_slave (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxWord(rxWord),
    .enterSlave(enterSlave), .txWord(txWord), .bufWe(bufWe),
    .bufAddr(bufAddr), .bufData(bufData), .isMaster(isMaster),
    .doneValid(doneValid), .doneCode(doneCode), .wdExpire(wdExpire)
  );

  always #10 clk = ~clk;

  // behavioural reference: 0 header wait, 1 payload, 2 acknowledge, 3 master
  int ms = 0, reqNext = 0, len = 0, cmd = 0, ackNext = 0, wd = 0;
  bit rej = 0, armed = 0, mDone = 0, mExp = 0;
  logic [31:0] mTx = '0, mReason = '0;
  int mCode = 0;
  int zeroSet[$] = '{'h27, 'h28, 'h29, 'h36};
  int paySet[$]  = '{'h28, 'h29, 'h36};

  function automatic bit inSet(int q[$], int c);
    foreach (q[i]) if (q[i] == c) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mClear();
    reqNext = 0; ackNext = 0; rej = 0;
  endtask

  task automatic mAck(bit ok);
    rej = !ok;
    mTx = ok ? (32'h9966_0000 | (cmd + 32'h80)) : 32'h9966_01EE;
    mReason = (cmd >= 'h10 && cmd <= 'h3D) ? 32'd1 : 32'd2;
    ackNext = 1;
    ms = 2;
  endtask

  task automatic mUpdate(bit v, logic [31:0] w, bit e);
    mDone = 0; mExp = 0;
    if (ms == 3) begin
      if (e) ms = 0;
    end else if (v) begin
      armed = 1; wd = W - 1;
      if (ms == 0) begin
        if (w[31:16] == 16'h9966) begin
          len = w[15:8]; cmd = w[7:0];
          if (len == 0) mAck(inSet(zeroSet, cmd));
          else begin mTx = POLL; reqNext = 1; ms = 1; end
        end
      end else if (ms == 1) begin
        reqNext++;
        if (reqNext > len) mAck(inSet(paySet, cmd));
        else mTx = POLL;
      end else if (ms == 2 && w == POLL) begin
        if (ackNext > int'(rej)) begin
          mDone = 1; armed = 0;
          if (rej) begin mCode = 'h1EE; ms = 0; end
          else begin mCode = (len << 8) | cmd; mTx = '0; ms = 3; end
          mClear();
        end else begin
          mTx = mReason; ackNext++;
        end
      end
    end else if (armed) begin
      if (wd == 0) begin mExp = 1; ms = 0; armed = 0; mClear(); end
      else wd--;
    end
  endtask

  task automatic cmpRegs();
    chk("R2 txWord vs model", txWord, mTx);
    chk("R8 isMaster vs model", 32'(isMaster), 32'(ms == 3));
    chk("R9 doneValid vs model", 32'(doneValid), 32'(mDone));
    if (mDone) chk("R9 doneCode vs model", 32'(doneCode), 32'(mCode));
    chk("R11 wdExpire vs model", 32'(wdExpire), 32'(mExp));
  endtask

  task automatic step(bit v, logic [31:0] w, bit e);
    bit expWe;
    @(negedge clk);
    cmpRegs();
    rxValid = v; rxWord = w; enterSlave = e;
    #1;
    expWe = v && (ms == 0 || ms == 1);
    chk("R10 bufWe vs model", 32'(bufWe), 32'(expWe));
    if (expWe) begin
      chk("R2 bufAddr vs model", 32'(bufAddr), (ms == 0) ? 32'd0 : 32'(reqNext));
      chk("R2 bufData vs model", bufData, w);
    end
    @(posedge clk);
    mUpdate(v, w, e);
    #2;
    rxValid = 1'b0; enterSlave = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog: run did not end actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R12 txWord after reset", txWord, 32'd0);
    chk("R12 isMaster after reset", 32'(isMaster), 32'd0);
    chk("R12 doneValid after reset", 32'(doneValid), 32'd0);

    step(1, 32'h1234_5678, 0);
    chk("R1 txWord after bad header", txWord, 32'd0);
    chk("R1 no report after bad header", 32'(doneValid), 32'd0);

    step(1, 32'h9966_0027, 0);
    chk("R3 accept header", txWord, 32'h9966_00A7);
    step(1, POLL, 0);
    chk("R8 doneValid", 32'(doneValid), 32'd1);
    chk("R8 doneCode", 32'(doneCode), 32'h0027);
    chk("R8 isMaster", 32'(isMaster), 32'd1);
    chk("R8 txWord cleared", txWord, 32'd0);

    step(1, 32'h9966_0015, 0);
    chk("R10 txWord while master", txWord, 32'd0);
    step(0, '0, 1);
    chk("R10 slave after enterSlave", 32'(isMaster), 32'd0);

    step(1, 32'h9966_0015, 0);
    chk("R4 reject header", txWord, 32'h9966_01EE);
    step(1, POLL, 0);
    chk("R5 reason in range", txWord, 32'd1);
    step(1, 32'hDEAD_BEEF, 0);
    chk("R7 non-poll keeps txWord", txWord, 32'd1);
    step(1, POLL, 0);
    chk("R9 reject code", 32'(doneCode), 32'h01EE);
    chk("R9 stays slave", 32'(isMaster), 32'd0);

    step(1, 32'h9966_0050, 0);
    chk("R4 reject header out of range", txWord, 32'h9966_01EE);
    step(1, POLL, 0);
    chk("R5 reason out of range", txWord, 32'd2);
    step(1, POLL, 0);

    step(1, 32'h9966_0228, 0);
    chk("R2 poll reply after header", txWord, POLL);
    step(1, 32'hAAAA_0001, 0);
    chk("R2 poll reply after word 1", txWord, POLL);
    step(1, 32'hBBBB_0002, 0);
    chk("R6 payload command accepted", txWord, 32'h9966_00A8);
    step(1, POLL, 0);
    chk("R8 payload doneCode", 32'(doneCode), 32'h0228);
    step(0, '0, 1);

    step(1, 32'h9966_0127, 0);
    step(1, 32'hCCCC_0003, 0);
    chk("R6 role-change command with payload rejected", txWord, 32'h9966_01EE);
    step(1, POLL, 0);
    chk("R5 reason for 0x27", txWord, 32'd1);
    step(1, POLL, 0);

    step(1, 32'h9966_0036, 0);
    chk("R3 accept header 0x36", txWord, 32'h9966_00B6);
    step(1, POLL, 0);
    step(0, '0, 1);

    step(1, 32'h9966_0328, 0);
    repeat (10) step(0, '0, 0);
    step(1, 32'h1111_1111, 0);
    repeat (19) step(0, '0, 0);
    chk("R11 no expiry before period", 32'(wdExpire), 32'd0);
    step(0, '0, 0);
    chk("R11 expiry pulse", 32'(wdExpire), 32'd1);
    step(0, '0, 0);
    chk("R11 pulse ends", 32'(wdExpire), 32'd0);
    step(1, 32'h9966_0029, 0);
    chk("R11 fresh header after expiry", txWord, 32'h9966_00A9);
    step(1, POLL, 0);
    step(0, '0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule